// File: doc/BRIEF.md
# PWM Timebase Counter with Sync Phase Load

This block is the time reference for a pulse-width modulation channel. A count register advances once per tick. The tick comes from two dividers in a chain. The first divider models a prescaler shared across timers and the second a prescaler private to this timer. The counter runs up, down, or up then down (a symmetric triangle) against a programmable period. It emits one-clock strobes when it reaches zero and when it reaches the period. It also drives a direction flag, so comparators and output generators downstream can place their edges.

Software writes configuration through a simple strobe interface: `cfg_we`, `cfg_addr` and `cfg_wdata`. It can also arm a sync input. While the timer runs, a sync pulse reloads the counter with a programmed phase, which lets several timebases be aligned. A period written during a cycle is held in a shadow register and applied when the count next lands on zero, so the running cycle keeps its full length.

Top module: `pwm_timebase`

## Requirements
- R1: With shared prescale S and timer prescale T, the counter advances once every (S+1)*(T+1) clocks. After the clock edge that accepts a start command, the first advance appears (S+1)*(T+1) edges later.
- R2: Mode code 0 counts up by one per tick and wraps from the active period to 0. Code 3 behaves the same as code 0. The direction output is 0 in these modes.
- R3: Mode code 1 counts down by one per tick and wraps from 0 to the active period. The direction output is 1 in this mode.
- R4: Mode code 2 counts up from 0 to the period, then down to 0, and repeats. The direction output becomes 1 on the tick that leaves the period and returns to 0 on the tick that leaves 0.
- R5: A write to address 0 with bit 0 set starts the timer, and one with bit 1 set stops it. Stop wins if both bits are set. A stopped timer holds its count, and a restart continues from the held value.
- R6: While the timer runs with sync enabled, a clock edge that samples `sync_in` high loads the phase value into the counter. This load takes priority over the tick and raises no event.
- R7: With sync enable cleared, `sync_in` has no effect, and the counter advances as if no pulse arrived.
- R8: `zero_evt_o` is high for exactly one clock, in the clock where a tick has just moved the count to 0.
- R9: `period_evt_o` is high for exactly one clock, in the clock where a tick has just moved the count to the active period.
- R10: A period write goes to a shadow register. It becomes active on the tick that moves the count to 0, or at once while the timer is stopped.
- R11: While the timer is stopped, neither event strobe is asserted.
- R12: After reset the count is 0, both strobes and the direction output are 0, and the timer is stopped. The reset values are mode 0, period 255, phase 0, sync disabled and both prescales 0.
- R13: A write takes effect at the clock edge that samples `cfg_we` high. The address map is: 0 control, 1 mode (bits 1:0), 2 period, 3 phase, 4 sync enable (bit 0), 5 shared prescale, 6 timer prescale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| sync_in | input | 1 | Sync pulse; reloads the phase when armed |
| cnt_o | output | 16 | Current count |
| zero_evt_o | output | 1 | One-clock strobe on reaching zero |
| period_evt_o | output | 1 | One-clock strobe on reaching the period |
| dir_down_o | output | 1 | 1 while the count is moving downward |

## Verification
The bench targets the wrap points of each mode. An off-by-one in the wrap compare would show a count of period+1 or skip zero. A direction flag that flips on arrival rather than departure would report the wrong direction at the triangle's apex and floor. It writes a shorter period partway through a cycle and expects the old cycle to run to its end. A design that applied the period at once would wrap early. It stops the timer just as a tick is due, then restarts it, and expects the count to be held with no strobes in between. It also checks that a stretched strobe under a prescaler, a sync pulse that loads while disabled, and a first tick that arrives one clock early or late are each caught.

// File: rtl/pwmtb_pkg.sv
`timescale 1ns/1ps
package pwmtb_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'd0,
    CM_DOWN = 2'd1,
    CM_UPDN = 2'd2,
    CM_RSVD = 2'd3
  } cnt_mode_e;

  localparam int unsigned CFG_AW = 3;

  localparam logic [CFG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [CFG_AW-1:0] A_MODE   = 3'd1;
  localparam logic [CFG_AW-1:0] A_PER    = 3'd2;
  localparam logic [CFG_AW-1:0] A_PHASE  = 3'd3;
  localparam logic [CFG_AW-1:0] A_SYNCEN = 3'd4;
  localparam logic [CFG_AW-1:0] A_PRE_SH = 3'd5;
  localparam logic [CFG_AW-1:0] A_PRE_TM = 3'd6;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;

endpackage

// File: rtl/pwmtb_rst_sync.sv
`timescale 1ns/1ps
module pwmtb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sn = sh_q[STAGES-1];

endmodule

// File: rtl/pwmtb_cfg_regs.sv
`timescale 1ns/1ps
module pwmtb_cfg_regs
  import pwmtb_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned RST_PERIOD = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output cnt_mode_e         mode_o,
  output logic [CNT_W-1:0]  per_sh_o,
  output logic [CNT_W-1:0]  phase_o,
  output logic              sync_en_o,
  output logic [PRE_W-1:0]  pre_sh_o,
  output logic [PRE_W-1:0]  pre_tm_o,
  output logic              start_o,
  output logic              stop_o
);

  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(RST_PERIOD);

  cnt_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             sen_q, sen_d;
  logic [PRE_W-1:0] psh_q, psh_d;
  logic [PRE_W-1:0] ptm_q, ptm_d;

  logic ctrl_wr;

  always_comb begin
    mode_d  = mode_q;
    per_d   = per_q;
    ph_d    = ph_q;
    sen_d   = sen_q;
    psh_d   = psh_q;
    ptm_d   = ptm_q;
    ctrl_wr = 1'b0;
    if (we_i) begin
      unique case (addr_i)
        A_CTRL:   ctrl_wr = 1'b1;
        A_MODE:   mode_d  = cnt_mode_e'(wdata_i[1:0]);
        A_PER:    per_d   = wdata_i;
        A_PHASE:  ph_d    = wdata_i;
        A_SYNCEN: sen_d   = wdata_i[0];
        A_PRE_SH: psh_d   = wdata_i[PRE_W-1:0];
        A_PRE_TM: ptm_d   = wdata_i[PRE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CM_UP;
      per_q  <= PER_RST;
      ph_q   <= '0;
      sen_q  <= 1'b0;
      psh_q  <= '0;
      ptm_q  <= '0;
    end else begin
      mode_q <= mode_d;
      per_q  <= per_d;
      ph_q   <= ph_d;
      sen_q  <= sen_d;
      psh_q  <= psh_d;
      ptm_q  <= ptm_d;
    end
  end

  assign start_o   = ctrl_wr & wdata_i[CTRL_START_BIT];
  assign stop_o    = ctrl_wr & wdata_i[CTRL_STOP_BIT];
  assign mode_o    = mode_q;
  assign per_sh_o  = per_q;
  assign phase_o   = ph_q;
  assign sync_en_o = sen_q;
  assign pre_sh_o  = psh_q;
  assign pre_tm_o  = ptm_q;

  AST_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_PER) |=> per_sh_o == $past(wdata_i)); // R13

endmodule

// File: rtl/pwmtb_div.sv
`timescale 1ns/1ps
module pwmtb_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);

  logic [W-1:0] q_q, q_d;
  logic         at_lim;

  assign at_lim = (q_q >= lim_i);

  always_comb begin
    if (clr_i) begin
      q_d = '0;
    end else if (en_i) begin
      q_d = at_lim ? '0 : q_q + 1'b1;
    end else begin
      q_d = q_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign tick_o = en_i & ~clr_i & at_lim;

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && lim_i != '0) |=> (!tick_o || lim_i != $past(lim_i))); // R1

endmodule

// File: rtl/pwmtb_counter.sv
`timescale 1ns/1ps
module pwmtb_counter
  import pwmtb_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_PERIOD = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] per_sh_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             sync_en_i,
  input  logic             sync_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o,
  output logic             per_evt_o,
  output logic             dir_down_o
);

  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(RST_PERIOD);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_act_q, per_act_d;
  logic             dn_q, dn_d;
  logic             zero_q, zero_d;
  logic             pev_q, pev_d;

  logic             sync_ld;
  logic             adv;
  logic [CNT_W-1:0] step;
  logic             dn_step;

  assign sync_ld = run_q & sync_en_i & sync_i;
  assign adv     = run_q & tick_i & ~sync_ld;

  // next count for one tick, per mode
  always_comb begin
    step    = cnt_q;
    dn_step = dn_q;
    unique case (mode_i)
      CM_DOWN: begin
        step    = (cnt_q == '0) ? per_act_q : cnt_q - 1'b1;
        dn_step = 1'b0;
      end
      CM_UPDN: begin
        if (!dn_q) begin
          if (cnt_q >= per_act_q) begin
            if (cnt_q == '0) begin
              step = '0;
            end else begin
              step    = cnt_q - 1'b1;
              dn_step = 1'b1;
            end
          end else begin
            step = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            dn_step = 1'b0;
            step    = (per_act_q == '0) ? '0 : CNT_W'(1);
          end else begin
            step = cnt_q - 1'b1;
          end
        end
      end
      default: begin
        step    = (cnt_q >= per_act_q) ? '0 : cnt_q + 1'b1;
        dn_step = 1'b0;
      end
    endcase
  end

  always_comb begin
    run_d = run_q;
    if (stop_i) begin
      run_d = 1'b0;
    end else if (start_i) begin
      run_d = 1'b1;
    end

    if (sync_ld) begin
      cnt_d = phase_i;
    end else if (adv) begin
      cnt_d = step;
    end else begin
      cnt_d = cnt_q;
    end

    if (mode_i != CM_UPDN) begin
      dn_d = 1'b0;
    end else if (adv) begin
      dn_d = dn_step;
    end else begin
      dn_d = dn_q;
    end

    if (!run_q || (adv && step == '0)) begin
      per_act_d = per_sh_i;
    end else begin
      per_act_d = per_act_q;
    end

    zero_d = adv & (step == '0);
    pev_d  = adv & (step == per_act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      per_act_q <= PER_RST;
      dn_q      <= 1'b0;
      zero_q    <= 1'b0;
      pev_q     <= 1'b0;
    end else begin
      run_q     <= run_d;
      cnt_q     <= cnt_d;
      per_act_q <= per_act_d;
      dn_q      <= dn_d;
      zero_q    <= zero_d;
      pev_q     <= pev_d;
    end
  end

  assign run_o      = run_q;
  assign cnt_o      = cnt_q;
  assign zero_evt_o = zero_q;
  assign per_evt_o  = pev_q;
  assign dir_down_o = (mode_i == CM_DOWN) | dn_q;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_q); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_q)); // R5
  AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!zero_q && !pev_q)); // R11
  AST_ZERO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> cnt_q == '0); // R8
  AST_ZERO_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_q && per_act_q != '0) |=> !zero_q); // R8
  AST_PER_AT_PER: assert property (@(posedge clk) disable iff (!rst_n)
    pev_q |-> cnt_q == $past(per_act_q)); // R9
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sync_en_i && sync_i) |=> cnt_q == $past(phase_i)); // R6
  AST_SHADOW_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act_q != $past(per_act_q)) |-> (cnt_q == '0 || !$past(run_q))); // R10
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_i == CM_UP && cnt_q < per_act_q) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_i == CM_DOWN && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R3

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned RST_PERIOD = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o,
  output logic             period_evt_o,
  output logic             dir_down_o
);

  localparam int unsigned NUM_DIV = 2;

  logic             rst_sn;
  cnt_mode_e        mode;
  logic [CNT_W-1:0] per_sh;
  logic [CNT_W-1:0] phase;
  logic             sync_en;
  logic [PRE_W-1:0] pre_sh;
  logic [PRE_W-1:0] pre_tm;
  logic             start_p;
  logic             stop_p;
  logic             run;
  logic [NUM_DIV:0] stg_en;
  logic [PRE_W-1:0] stg_lim [NUM_DIV];

  pwmtb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pwmtb_cfg_regs #(
    .CNT_W      (CNT_W),
    .PRE_W      (PRE_W),
    .RST_PERIOD (RST_PERIOD)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sn),
    .we_i      (cfg_we),
    .addr_i    (cfg_addr),
    .wdata_i   (cfg_wdata),
    .mode_o    (mode),
    .per_sh_o  (per_sh),
    .phase_o   (phase),
    .sync_en_o (sync_en),
    .pre_sh_o  (pre_sh),
    .pre_tm_o  (pre_tm),
    .start_o   (start_p),
    .stop_o    (stop_p)
  );

  // divider chain: shared stage first, then the timer's own stage
  assign stg_en[0]  = run;
  assign stg_lim[0] = pre_sh;
  assign stg_lim[1] = pre_tm;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    pwmtb_div #(.W(PRE_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_sn),
      .clr_i  (~run),
      .en_i   (stg_en[g]),
      .lim_i  (stg_lim[g]),
      .tick_o (stg_en[g+1])
    );
  end

  pwmtb_counter #(
    .CNT_W      (CNT_W),
    .RST_PERIOD (RST_PERIOD)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .tick_i     (stg_en[NUM_DIV]),
    .mode_i     (mode),
    .per_sh_i   (per_sh),
    .phase_i    (phase),
    .sync_en_i  (sync_en),
    .sync_i     (sync_in),
    .run_o      (run),
    .cnt_o      (cnt_o),
    .zero_evt_o (zero_evt_o),
    .per_evt_o  (period_evt_o),
    .dir_down_o (dir_down_o)
  );

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_sn)
    !run |-> !stg_en[NUM_DIV]); // R1

endmodule

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        sync_in;
  logic [15:0] cnt_o;
  logic        zero_evt_o;
  logic        period_evt_o;
  logic        dir_down_o;

  int n_chk;
  int n_bad;

  pwm_timebase dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .sync_in      (sync_in),
    .cnt_o        (cnt_o),
    .zero_evt_o   (zero_evt_o),
    .period_evt_o (period_evt_o),
    .dir_down_o   (dir_down_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] per;
    logic [7:0]  sp;
    logic [7:0]  tp;
    logic [15:0] ticks;
    logic [15:0] exp_cnt;
    logic        exp_dir;
  } vec_t;

  // mode, period, shared pre, timer pre, ticks, expected count, expected dir
  localparam vec_t VEC [11] = '{
    '{2'd0, 16'd9, 8'd0, 8'd0, 16'd5,  16'd5, 1'b0},
    '{2'd0, 16'd9, 8'd0, 8'd0, 16'd10, 16'd0, 1'b0},
    '{2'd0, 16'd9, 8'd0, 8'd0, 16'd13, 16'd3, 1'b0},
    '{2'd0, 16'd4, 8'd1, 8'd2, 16'd7,  16'd2, 1'b0},
    '{2'd1, 16'd9, 8'd0, 8'd0, 16'd1,  16'd9, 1'b1},
    '{2'd1, 16'd9, 8'd0, 8'd0, 16'd4,  16'd6, 1'b1},
    '{2'd1, 16'd9, 8'd1, 8'd0, 16'd11, 16'd9, 1'b1},
    '{2'd2, 16'd4, 8'd0, 8'd0, 16'd4,  16'd4, 1'b0},
    '{2'd2, 16'd4, 8'd0, 8'd0, 16'd6,  16'd2, 1'b1},
    '{2'd2, 16'd4, 8'd0, 8'd0, 16'd8,  16'd0, 1'b1},
    '{2'd2, 16'd4, 8'd2, 8'd0, 16'd11, 16'd3, 1'b0}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [15:0] p,
                       input logic [7:0] s, input logic [7:0] t);
    do_reset();
    cfg_write(3'd5, {8'd0, s});
    cfg_write(3'd6, {8'd0, t});
    cfg_write(3'd1, {14'd0, m});
    cfg_write(3'd2, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int zc;
    int pc;
    int wide;
    logic [15:0] held;
    logic        prev_z;
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    sync_in   = 1'b0;

    // R12: reset state
    do_reset();
    chk("R12", "reset count", cnt_o, 0);
    chk("R12", "reset zero evt", zero_evt_o, 0);
    chk("R12", "reset period evt", period_evt_o, 0);
    chk("R12", "reset dir", dir_down_o, 0);
    repeat (5) @(negedge clk);
    chk("R12", "stays stopped after reset", cnt_o, 0);

    // vector table: R2 R3 R4 R1 R13
    for (int i = 0; i < 11; i++) begin
      setup(VEC[i].mode, VEC[i].per, VEC[i].sp, VEC[i].tp);
      cfg_write(3'd0, 16'd1);
      repeat (int'(VEC[i].ticks) * (int'(VEC[i].sp) + 1) * (int'(VEC[i].tp) + 1))
        @(negedge clk);
      chk(VEC[i].mode == 2'd0 ? "R2" : (VEC[i].mode == 2'd1 ? "R3" : "R4"),
          $sformatf("vector %0d count", i), cnt_o, VEC[i].exp_cnt);
      chk(VEC[i].mode == 2'd2 ? "R4" : "R3", $sformatf("vector %0d dir", i),
          dir_down_o, VEC[i].exp_dir);
    end

    // R1: first tick lands exactly (S+1)*(T+1) edges after start
    setup(2'd0, 16'd255, 8'd3, 8'd1);
    cfg_write(3'd0, 16'd1);
    repeat (7) @(negedge clk);
    chk("R1", "no tick before 8 clocks", cnt_o, 0);
    @(negedge clk);
    chk("R1", "tick at 8 clocks", cnt_o, 1);

    // R8 R9: event pulses, unprescaled, up mode period 3
    setup(2'd0, 16'd3, 8'd0, 8'd0);
    cfg_write(3'd0, 16'd1);
    zc = 0; pc = 0; wide = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (zero_evt_o) begin
        zc++;
        if (cnt_o != 16'd0) wide++;
      end
      if (period_evt_o) begin
        pc++;
        if (cnt_o != 16'd3) wide++;
      end
    end
    chk("R8", "zero pulses in 12 ticks", zc, 3);
    chk("R9", "period pulses in 12 ticks", pc, 3);
    chk("R8", "strobes aligned with count", wide, 0);

    // R8: strobe stays one clock wide under a prescaler
    setup(2'd0, 16'd3, 8'd2, 8'd0);
    cfg_write(3'd0, 16'd1);
    zc = 0; wide = 0; prev_z = 1'b0;
    for (int k = 1; k <= 36; k++) begin
      @(negedge clk);
      if (zero_evt_o) zc++;
      if (zero_evt_o && prev_z) wide++;
      prev_z = zero_evt_o;
    end
    chk("R8", "zero pulses prescaled", zc, 3);
    chk("R8", "zero pulse width", wide, 0);

    // R5 R11: stop holds, stop wins, restart resumes
    setup(2'd0, 16'd255, 8'd0, 8'd0);
    cfg_write(3'd0, 16'd1);
    repeat (5) @(negedge clk);
    cfg_write(3'd0, 16'd2);
    held = cnt_o;
    chk("R5", "count at stop", held, 7);
    zc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (zero_evt_o || period_evt_o) zc++;
    end
    chk("R5", "count held while stopped", cnt_o, held);
    chk("R11", "no strobes while stopped", zc, 0);
    cfg_write(3'd0, 16'd3);
    repeat (5) @(negedge clk);
    chk("R5", "stop wins over start", cnt_o, held);
    cfg_write(3'd0, 16'd1);
    @(negedge clk);
    chk("R5", "restart continues", cnt_o, held + 16'd1);

    // R6: sync loads phase
    setup(2'd0, 16'd99, 8'd0, 8'd0);
    cfg_write(3'd3, 16'd40);
    cfg_write(3'd4, 16'd1);
    cfg_write(3'd0, 16'd1);
    repeat (3) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R6", "phase loaded", cnt_o, 40);
    chk("R6", "no strobe on load", {zero_evt_o, period_evt_o}, 0);
    @(negedge clk);
    chk("R6", "counts on from phase", cnt_o, 41);

    // R7: sync ignored when disabled
    cfg_write(3'd4, 16'd0);
    held = cnt_o;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R7", "sync ignored", cnt_o, held + 16'd1);

    // R10: period shadow applies at next zero
    setup(2'd0, 16'd9, 8'd0, 8'd0);
    cfg_write(3'd0, 16'd1);
    repeat (2) @(negedge clk);
    cfg_write(3'd2, 16'd5);
    repeat (5) @(negedge clk);
    chk("R10", "old period finishes", cnt_o, 9);
    repeat (6) @(negedge clk);
    chk("R10", "new period reached", cnt_o, 5);
    chk("R9", "period strobe at new period", period_evt_o, 1);
    @(negedge clk);
    chk("R10", "wrap at new period", cnt_o, 0);
    chk("R8", "zero strobe after wrap", zero_evt_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule